// File: doc/BRIEF.md
# SCSI Data-In Auto-Acknowledge Port

This block sits between a processor bus and the initiator side of a SCSI bus while a READ(6) command moves data from the target to the host. A processor read of the data port returns the byte currently on the bus. If the bus is in the data-in phase at that moment, the same read also raises ACK at once. The processor never polls REQ itself. Instead, the block holds a stall request toward the processor until the target raises REQ for the next byte.

When the target finishes and the bus goes free, the next port read sees it. This works through an armed "completion-checked" flag. The first data-in read clears the flag. The first port read that then finds the bus free sets it again, drops ACK and raises a transfer-done interrupt. The interrupt stays high until the processor acknowledges it.

Top module: `sdi_autoack_port`

## Requirements
- R1: After synchronous reset, `bus_ack`, `cpu_stall` and `irq_done` are 0, `cpu_rdata` is 0, and the completion-checked flag is set. A bus-free read right after reset therefore raises no interrupt.
- R2: The data-in phase is `cmd_is_read6`=1 with BSY=1, REQ=1, C/D=0, MSG=0 and I/O=1. A port read at offset 0x1 in that phase puts `bus_data` on `cpu_rdata` and sets `bus_ack` from the next cycle.
- R3: A port read at offset 0x8 behaves the same as a read at offset 0x1.
- R4: A read at any other offset leaves `cpu_rdata`, `bus_ack` and `cpu_stall` unchanged.
- R5: A port read outside the data-in phase returns `bus_data` but raises neither ACK nor stall. This covers the case where C/D=1 and the case where the command is not READ(6).
- R6: `cpu_stall` rises together with ACK on a data-in read. It stays high until a cycle in which REQ is high after being low the cycle before, and it is low from the cycle after that. A data-in read in that same cycle keeps it high.
- R7: While ACK is high and REQ is sampled low, ACK is low from the next cycle.
- R8: After a data-in read has cleared the flag, a port read with READ(6) active and BSY, REQ, C/D, MSG and I/O all low sets the flag, forces ACK low and raises `irq_done` in the next cycle.
- R9: While the flag is set, a bus-free read raises no interrupt.
- R10: `irq_done` holds until a cycle with `irq_clr`=1 and no completion. It is 0 from the next cycle.
- R11: If a completion and `irq_clr` fall in the same cycle, `irq_done` is 1 afterwards.
- R12: A bus-free read while the command is not READ(6) raises no interrupt and leaves the flag clear.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cpu_rd | input | 1 | Processor read strobe, one cycle per access |
| cpu_addr | input | 4 | Register offset of the access |
| cpu_rdata | output | 8 | Byte returned by the last port read |
| irq_clr | input | 1 | Interrupt acknowledge strobe |
| cmd_is_read6 | input | 1 | Active command is READ(6) |
| bus_bsy | input | 1 | SCSI BSY |
| bus_req | input | 1 | SCSI REQ |
| bus_cd | input | 1 | SCSI C/D |
| bus_msg | input | 1 | SCSI MSG |
| bus_io | input | 1 | SCSI I/O |
| bus_data | input | 8 | SCSI data byte |
| bus_ack | output | 1 | SCSI ACK driven by the initiator |
| cpu_stall | output | 1 | Bus-request stall toward the processor |
| irq_done | output | 1 | Transfer-done interrupt |

## Verification
Two functions can fall in the same cycle here. One is the completion that sets the interrupt. The other is the processor's acknowledge that clears it. The bench provokes the collision by pulsing `irq_clr` in the very cycle of the bus-free port read that ends a transfer. It judges the result by finding `irq_done` still high in the following cycle, and only a lone acknowledge one cycle later brings it low. A second overlap is also exercised: a REQ rising edge in the same cycle as a fresh data-in read, where the stall must stay asserted.

// File: rtl/sdi_pkg.sv
package sdi_pkg;

    // SCSI control lines as seen by the initiator
    typedef struct packed {
        logic bsy;
        logic req;
        logic cd;
        logic msg;
        logic io;
    } bus_ctl_t;

    typedef enum logic [1:0] {
        PH_OTHER    = 2'd0,
        PH_DATA_IN  = 2'd1,
        PH_BUS_FREE = 2'd2
    } bus_phase_e;

    // Phase classification; only meaningful while READ(6) is active
    function automatic bus_phase_e classify(input logic is_read6, input bus_ctl_t c);
        if (!is_read6)
            return PH_OTHER;
        if (c.bsy && c.req && !c.cd && !c.msg && c.io)
            return PH_DATA_IN;
        if (c == '0)
            return PH_BUS_FREE;
        return PH_OTHER;
    endfunction

endpackage

// File: rtl/sdi_phase_decode.sv
module sdi_phase_decode
    import sdi_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       is_read6,
    input  bus_ctl_t   ctl,
    output bus_phase_e phase,
    output logic       req_rise
);
    logic req_q;

    always_ff @(posedge clk) begin
        if (rst) req_q <= 1'b0;
        else     req_q <= ctl.req;
    end

    always_comb begin
        phase    = classify(is_read6, ctl);
        req_rise = ctl.req && !req_q;
    end

endmodule

// File: rtl/sdi_handshake.sv
module sdi_handshake
    import sdi_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       rd_hit,
    input  bus_phase_e phase,
    input  logic       req_now,
    input  logic       req_rise,
    input  logic       done_set,
    output logic       datain_read,
    output logic       ack,
    output logic       stall
);
    logic ack_q, stall_q;

    assign datain_read = rd_hit && (phase == PH_DATA_IN);
    assign ack   = ack_q;
    assign stall = stall_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            ack_q   <= 1'b0;
            stall_q <= 1'b0;
        end else begin
            if (ack_q && !req_now) ack_q   <= 1'b0;
            if (done_set)          ack_q   <= 1'b0;
            if (stall_q && req_rise) stall_q <= 1'b0;
            if (datain_read) begin
                ack_q   <= 1'b1;
                stall_q <= 1'b1;
            end
        end
    end

    AST_ACK_FROM_READ: assert property (@(posedge clk) disable iff (rst)
        $rose(ack_q) |-> $past(rd_hit && phase == PH_DATA_IN));            // R2
    AST_ACK_DROP: assert property (@(posedge clk) disable iff (rst)
        (ack_q && !req_now && !datain_read) |=> !ack_q);                  // R7
    AST_STALL_HOLD: assert property (@(posedge clk) disable iff (rst)
        (stall_q && !req_rise) |=> stall_q);                              // R6
    AST_STALL_DROP: assert property (@(posedge clk) disable iff (rst)
        (stall_q && req_rise && !datain_read) |=> !stall_q);              // R6

endmodule

// File: rtl/sdi_done_flag.sv
module sdi_done_flag
    import sdi_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       rd_hit,
    input  logic       datain_read,
    input  bus_phase_e phase,
    input  logic       irq_clr,
    output logic       done_set,
    output logic       irq
);
    logic checked_q, irq_q;

    assign done_set = rd_hit && !checked_q && (phase == PH_BUS_FREE);
    assign irq      = irq_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            checked_q <= 1'b1;
            irq_q     <= 1'b0;
        end else begin
            if (datain_read) checked_q <= 1'b0;
            if (done_set)    checked_q <= 1'b1;
            if (irq_clr)     irq_q     <= 1'b0;
            if (done_set)    irq_q     <= 1'b1;
        end
    end

    AST_IRQ_HOLD: assert property (@(posedge clk) disable iff (rst)
        (irq_q && !irq_clr) |=> irq_q);                                   // R10
    AST_SET_WINS: assert property (@(posedge clk) disable iff (rst)
        (done_set && irq_clr) |=> irq_q);                                 // R11
    AST_IRQ_CAUSE: assert property (@(posedge clk) disable iff (rst)
        $rose(irq_q) |-> $past(rd_hit && phase == PH_BUS_FREE));          // R8
    AST_NO_REARM: assert property (@(posedge clk) disable iff (rst)
        (checked_q && !datain_read) |=> checked_q);                       // R9

endmodule

// File: rtl/sdi_autoack_port.sv
module sdi_autoack_port
    import sdi_pkg::*;
#(
    parameter int ADDR_W  = 4,
    parameter int DATA_W  = 8,
    parameter int NUM_OFS = 2,
    parameter logic [NUM_OFS-1:0][ADDR_W-1:0] PORT_OFS = {4'h8, 4'h1}
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              cpu_rd,
    input  logic [ADDR_W-1:0] cpu_addr,
    output logic [DATA_W-1:0] cpu_rdata,
    input  logic              irq_clr,
    input  logic              cmd_is_read6,
    input  logic              bus_bsy,
    input  logic              bus_req,
    input  logic              bus_cd,
    input  logic              bus_msg,
    input  logic              bus_io,
    input  logic [DATA_W-1:0] bus_data,
    output logic              bus_ack,
    output logic              cpu_stall,
    output logic              irq_done
);
    bus_ctl_t          ctl;
    bus_phase_e        phase;
    logic              req_rise, rd_hit, datain_read, done_set;
    logic [NUM_OFS-1:0] ofs_match;
    logic [DATA_W-1:0] rdata_q;

    assign ctl = '{bsy: bus_bsy, req: bus_req, cd: bus_cd, msg: bus_msg, io: bus_io};

    for (genvar g = 0; g < NUM_OFS; g++) begin : g_ofs
        assign ofs_match[g] = (cpu_addr == PORT_OFS[g]);
    end
    assign rd_hit = cpu_rd && (|ofs_match);

    sdi_phase_decode u_dec (
        .clk(clk), .rst(rst), .is_read6(cmd_is_read6), .ctl(ctl),
        .phase(phase), .req_rise(req_rise)
    );

    sdi_handshake u_hs (
        .clk(clk), .rst(rst), .rd_hit(rd_hit), .phase(phase),
        .req_now(bus_req), .req_rise(req_rise), .done_set(done_set),
        .datain_read(datain_read), .ack(bus_ack), .stall(cpu_stall)
    );

    sdi_done_flag u_done (
        .clk(clk), .rst(rst), .rd_hit(rd_hit), .datain_read(datain_read),
        .phase(phase), .irq_clr(irq_clr), .done_set(done_set), .irq(irq_done)
    );

    always_ff @(posedge clk) begin
        if (rst)         rdata_q <= '0;
        else if (rd_hit) rdata_q <= bus_data;
    end
    assign cpu_rdata = rdata_q;

    AST_RDATA_CAPTURE: assert property (@(posedge clk) disable iff (rst)
        rd_hit |=> (cpu_rdata == $past(bus_data)));                       // R2
    AST_RDATA_STABLE: assert property (@(posedge clk) disable iff (rst)
        !rd_hit |=> $stable(cpu_rdata));                                  // R4

endmodule

// File: tb/sdi_autoack_port_bench.sv
module sdi_autoack_port_bench;

    typedef struct packed {
        logic       rd;
        logic [3:0] addr;
        logic       r6;
        logic [4:0] ctl;   // {bsy, req, cd, msg, io}
        logic [7:0] data;
        logic       clr;
        logic       eack;
        logic       estall;
        logic       eirq;
        logic [7:0] erd;
        logic [3:0] tag;
    } vec_t;

    localparam int NV = 20;
    localparam vec_t VEC [NV] = '{
        vec_t'({1'b1,4'h1,1'b1,5'b00000,8'h00,1'b0,1'b0,1'b0,1'b0,8'h00,4'd1}),  // R1 armed flag
        vec_t'({1'b1,4'h1,1'b1,5'b11001,8'hA5,1'b0,1'b1,1'b1,1'b0,8'hA5,4'd2}),  // R2
        vec_t'({1'b0,4'h0,1'b1,5'b10001,8'h00,1'b0,1'b0,1'b1,1'b0,8'hA5,4'd7}),  // R7
        vec_t'({1'b0,4'h0,1'b1,5'b11001,8'h00,1'b0,1'b0,1'b0,1'b0,8'hA5,4'd6}),  // R6
        vec_t'({1'b1,4'h8,1'b1,5'b11001,8'h3C,1'b0,1'b1,1'b1,1'b0,8'h3C,4'd3}),  // R3
        vec_t'({1'b0,4'h0,1'b1,5'b11001,8'h00,1'b0,1'b1,1'b1,1'b0,8'h3C,4'd6}),  // R6 hold
        vec_t'({1'b0,4'h0,1'b1,5'b10001,8'h00,1'b0,1'b0,1'b1,1'b0,8'h3C,4'd7}),  // R7
        vec_t'({1'b1,4'h5,1'b1,5'b11001,8'h77,1'b0,1'b0,1'b0,1'b0,8'h3C,4'd4}),  // R4
        vec_t'({1'b1,4'h1,1'b1,5'b11101,8'h99,1'b0,1'b0,1'b0,1'b0,8'h99,4'd5}),  // R5 C/D=1
        vec_t'({1'b1,4'h1,1'b0,5'b11001,8'h11,1'b0,1'b0,1'b0,1'b0,8'h11,4'd5}),  // R5 not READ6
        vec_t'({1'b1,4'h1,1'b0,5'b00000,8'h00,1'b0,1'b0,1'b0,1'b0,8'h00,4'd12}), // R12
        vec_t'({1'b1,4'h8,1'b1,5'b00000,8'h00,1'b0,1'b0,1'b0,1'b1,8'h00,4'd8}),  // R8
        vec_t'({1'b0,4'h0,1'b1,5'b00000,8'h00,1'b0,1'b0,1'b0,1'b1,8'h00,4'd10}), // R10 hold
        vec_t'({1'b0,4'h0,1'b1,5'b00000,8'h00,1'b1,1'b0,1'b0,1'b0,8'h00,4'd10}), // R10 clear
        vec_t'({1'b1,4'h1,1'b1,5'b00000,8'h00,1'b0,1'b0,1'b0,1'b0,8'h00,4'd9}),  // R9
        vec_t'({1'b1,4'h1,1'b1,5'b11001,8'h5A,1'b0,1'b1,1'b1,1'b0,8'h5A,4'd2}),  // R2
        vec_t'({1'b0,4'h0,1'b1,5'b10001,8'h00,1'b0,1'b0,1'b1,1'b0,8'h5A,4'd7}),  // R7
        vec_t'({1'b0,4'h0,1'b1,5'b11101,8'h00,1'b0,1'b0,1'b0,1'b0,8'h5A,4'd6}),  // R6 status REQ
        vec_t'({1'b1,4'h1,1'b1,5'b00000,8'h00,1'b1,1'b0,1'b0,1'b1,8'h00,4'd11}), // R11
        vec_t'({1'b0,4'h0,1'b1,5'b00000,8'h00,1'b1,1'b0,1'b0,1'b0,8'h00,4'd10})  // R10
    };

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       cpu_rd = 1'b0;
    logic [3:0] cpu_addr = '0;
    logic [7:0] cpu_rdata;
    logic       irq_clr = 1'b0;
    logic       cmd_is_read6 = 1'b0;
    logic [4:0] ctl = '0;
    logic [7:0] bus_data = '0;
    logic       bus_ack, cpu_stall, irq_done;
    int         n_checks = 0;
    int         n_fail = 0;
    bit         finished = 1'b0;

    always #10 clk = ~clk;

    sdi_autoack_port u_sdi_autoack_port (
        .clk(clk), .rst(rst), .cpu_rd(cpu_rd), .cpu_addr(cpu_addr),
        .cpu_rdata(cpu_rdata), .irq_clr(irq_clr), .cmd_is_read6(cmd_is_read6),
        .bus_bsy(ctl[4]), .bus_req(ctl[3]), .bus_cd(ctl[2]), .bus_msg(ctl[1]),
        .bus_io(ctl[0]), .bus_data(bus_data), .bus_ack(bus_ack),
        .cpu_stall(cpu_stall), .irq_done(irq_done)
    );

    task automatic check(input int tag, input string what, input int got, input int exp);
        n_checks++;
        if (got != exp) begin
            n_fail++;
            $display("FAIL R%0d %s: actual %0h expected %0h", tag, what, got, exp);
        end
    endtask

    task automatic check_all(input int tag, input logic ea, input logic es,
                             input logic ei, input logic [7:0] er);
        check(tag, "bus_ack",   int'(bus_ack),   int'(ea));
        check(tag, "cpu_stall", int'(cpu_stall), int'(es));
        check(tag, "irq_done",  int'(irq_done),  int'(ei));
        check(tag, "cpu_rdata", int'(cpu_rdata), int'(er));
    endtask

    task automatic drive(input logic rd, input logic [3:0] a, input logic r6,
                         input logic [4:0] c, input logic [7:0] d, input logic cl);
        @(negedge clk);
        cpu_rd = rd; cpu_addr = a; cmd_is_read6 = r6;
        ctl = c; bus_data = d; irq_clr = cl;
        @(posedge clk);
        #1;
    endtask

    initial begin
        repeat (3) @(posedge clk);
        #1;
        check_all(1, 1'b0, 1'b0, 1'b0, 8'h00);                 // R1 reset values
        @(negedge clk);
        rst = 1'b0;

        for (int i = 0; i < NV; i++) begin
            drive(VEC[i].rd, VEC[i].addr, VEC[i].r6, VEC[i].ctl, VEC[i].data, VEC[i].clr);
            check_all(int'(VEC[i].tag), VEC[i].eack, VEC[i].estall, VEC[i].eirq, VEC[i].erd);
        end

        // R1: reset in the middle of a transfer
        drive(1'b1, 4'h1, 1'b1, 5'b11001, 8'hC3, 1'b0);
        check_all(2, 1'b1, 1'b1, 1'b0, 8'hC3);
        @(negedge clk);
        rst = 1'b1; cpu_rd = 1'b0;
        @(posedge clk);
        #1;
        check_all(1, 1'b0, 1'b0, 1'b0, 8'h00);
        @(negedge clk);
        rst = 1'b0;
        drive(1'b1, 4'h1, 1'b1, 5'b00000, 8'h00, 1'b0);        // R1 flag armed by reset
        check(1, "irq_done after reset", int'(irq_done), 0);

        // R6: REQ rises in the same cycle as a new data-in read
        drive(1'b1, 4'h1, 1'b1, 5'b11001, 8'h42, 1'b0);
        drive(1'b0, 4'h0, 1'b1, 5'b10001, 8'h00, 1'b0);
        check(6, "stall while REQ low", int'(cpu_stall), 1);
        drive(1'b1, 4'h8, 1'b1, 5'b11001, 8'h24, 1'b0);
        check_all(6, 1'b1, 1'b1, 1'b0, 8'h24);

        @(negedge clk);
        cpu_rd = 1'b0;
        finished = 1'b1;
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            n_checks++;
            n_fail++;
            $display("FAIL R0 watchdog: actual timeout expected completion");
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    end

endmodule